// File: doc/BRIEF.md
# Operand Extension Move Unit

The unit computes the write-back value of register-to-register moves that widen a narrow source operand. A decoded selector picks the operation. The selector is an escape bit plus an opcode byte: the escaped bytes B6, B7, BE and BF, or the unescaped byte 63. A two-bit size code gives the operand size of the destination. The unit reads a 64-bit source value and the current 64-bit destination register value. From these it returns the full 64-bit value to write back into the destination register.

The escaped forms sign- or zero-extend an 8-bit or 16-bit source. The unescaped form 63 handles a 32-bit source, and its behaviour depends on the size code. At 64-bit size it sign-extends. At 32-bit size it zero-extends. At 16-bit size it copies 16 bits and keeps the upper destination bits.

The result is registered and appears one cycle after the request, with a valid strobe. Any unsupported selector or size code is reported on an illegal flag. The flag word passes through untouched, because none of these moves alters a flag.

Top module: `ext_move_unit`

## Requirements
- R1: While rst_ni is low, valid_o, illegal_o, data_o and flags_o are all zero.
- R2: With esc_i=1 and opc_i=8'hBE, the low 8 source bits are sign-extended to the operand size. Size code 0 is 16 bits, code 1 is 32 bits and code 2 is 64 bits.
- R3: With esc_i=1 and opc_i=8'hBF, the low 16 source bits are sign-extended to the operand size. At size code 0 this is a plain 16-bit copy.
- R4: With esc_i=1, opc_i=8'hB6 zero-extends the low 8 source bits and opc_i=8'hB7 zero-extends the low 16 source bits, each to the operand size.
- R5: For the escaped forms, a 32-bit result (size code 1) clears data_o[63:32]. A 16-bit result (size code 0) leaves data_o[63:16] equal to dst_i[63:16].
- R6: With esc_i=0, opc_i=8'h63 and size code 2, data_o is the low 32 source bits sign-extended to 64 bits.
- R7: With esc_i=0, opc_i=8'h63 and size code 1, data_o is the low 32 source bits zero-extended to 64 bits.
- R8: With esc_i=0, opc_i=8'h63 and size code 0, data_o[15:0] is src_i[15:0] and data_o[63:16] is dst_i[63:16].
- R9: For every accepted request, flags_o one cycle later equals the flags_i of that request.
- R10: valid_o equals valid_i of the previous cycle. While valid_i is low, data_o, flags_o and illegal_o hold their values.
- R11: A request is illegal if its size code is 3, or if its selector is anything other than the five encodings above. For such a request, illegal_o is 1 and data_o equals dst_i one cycle later. For a legal request, illegal_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| esc_i | input | 1 | 1: opc_i follows the two-byte escape; 0: single-byte opcode |
| opc_i | input | 8 | Opcode byte |
| size_i | input | 2 | Operand size: 0=16, 1=32, 2=64, 3 reserved |
| src_i | input | XLEN | Source operand |
| dst_i | input | XLEN | Current destination register value |
| flags_i | input | FLAG_W | Current flag word |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| illegal_o | output | 1 | Request selector or size not supported |
| data_o | output | XLEN | Value to write back |
| flags_o | output | FLAG_W | Flag word to write back (unchanged) |

## Verification
The checker tests several properties on every cycle:
- the one-cycle valid strobe and the holding of all outputs while idle;
- the flag pass-through;
- the illegal flag together with the returned destination value;
- the cleared upper half on 32-bit results and the kept upper bits on 16-bit results;
- the replication of the sign bit for the 64-bit sign-extending forms.

The exact widened value of each form needs the bench sweep, and so does the choice between sign and zero extension made by form 63 at each size. The sweep covers every opcode byte, both escape values and all size codes. Each combination runs against source patterns whose bits 7, 15 and 31 take both polarities.

// File: rtl/ext_move_pkg.sv
package ext_move_pkg;
  localparam logic [7:0] OPC_ZX_B = 8'hB6;
  localparam logic [7:0] OPC_ZX_H = 8'hB7;
  localparam logic [7:0] OPC_SX_B = 8'hBE;
  localparam logic [7:0] OPC_SX_H = 8'hBF;
  localparam logic [7:0] OPC_SX_W = 8'h63;

  typedef enum logic [1:0] {
    SZ_16  = 2'd0,
    SZ_32  = 2'd1,
    SZ_64  = 2'd2,
    SZ_RSV = 2'd3
  } opsz_e;

  typedef enum logic [1:0] {
    SRC_B = 2'd0,
    SRC_H = 2'd1,
    SRC_W = 2'd2
  } srcw_e;

  localparam int unsigned NUM_SRCW = 3;

  typedef struct packed {
    logic  illegal;
    logic  sext;
    srcw_e srcw;
    opsz_e dsz;
  } ctl_t;
endpackage

// File: rtl/ext_move_decode.sv
module ext_move_decode
  import ext_move_pkg::*;
(
  input  logic       esc_i,
  input  logic [7:0] opc_i,
  input  logic [1:0] size_i,
  output ctl_t       ctl_o
);
  opsz_e sz;
  logic  hit;

  assign sz = opsz_e'(size_i);

  always_comb begin
    hit        = 1'b0;
    ctl_o.sext = 1'b0;
    ctl_o.srcw = SRC_B;
    ctl_o.dsz  = sz;
    if (esc_i) begin
      unique case (opc_i)
        OPC_ZX_B: begin hit = 1'b1; ctl_o.srcw = SRC_B; end
        OPC_ZX_H: begin hit = 1'b1; ctl_o.srcw = SRC_H; end
        OPC_SX_B: begin hit = 1'b1; ctl_o.srcw = SRC_B; ctl_o.sext = 1'b1; end
        OPC_SX_H: begin hit = 1'b1; ctl_o.srcw = SRC_H; ctl_o.sext = 1'b1; end
        default:  hit = 1'b0;
      endcase
    end else if (opc_i == OPC_SX_W) begin
      hit = 1'b1;
      // doubleword form: sign only at full size, 16-bit copy at 16-bit size
      ctl_o.sext = (sz == SZ_64);
      ctl_o.srcw = (sz == SZ_16) ? SRC_H : SRC_W;
    end
    ctl_o.illegal = !(hit && (sz != SZ_RSV));
  end
endmodule

// File: rtl/ext_move_extend.sv
module ext_move_extend
  import ext_move_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] src_i,
  input  srcw_e           srcw_i,
  input  logic            sext_i,
  output logic [XLEN-1:0] ext_o
);
  logic [XLEN-1:0] cand [NUM_SRCW];

  for (genvar g = 0; g < NUM_SRCW; g++) begin : g_w
    localparam int unsigned W = 8 << g;
    logic fill;
    assign fill    = sext_i & src_i[W-1];
    assign cand[g] = {{(XLEN-W){fill}}, src_i[W-1:0]};
  end

  always_comb begin
    unique case (srcw_i)
      SRC_H:   ext_o = cand[1];
      SRC_W:   ext_o = cand[2];
      default: ext_o = cand[0];
    endcase
  end
endmodule

// File: rtl/ext_move_merge.sv
module ext_move_merge
  import ext_move_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic [XLEN-1:0] ext_i,
  input  logic [XLEN-1:0] dst_i,
  input  opsz_e           dsz_i,
  input  logic            illegal_i,
  output logic [XLEN-1:0] res_o
);
  localparam int unsigned LO16 = 16;
  localparam int unsigned LO32 = 32;

  always_comb begin
    if (illegal_i) begin
      res_o = dst_i;
    end else begin
      unique case (dsz_i)
        SZ_16:   res_o = {dst_i[XLEN-1:LO16], ext_i[LO16-1:0]};
        SZ_32:   res_o = {{(XLEN-LO32){1'b0}}, ext_i[LO32-1:0]};
        default: res_o = ext_i;
      endcase
    end
  end
endmodule

// File: rtl/ext_move_unit.sv
module ext_move_unit
  import ext_move_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned FLAG_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              esc_i,
  input  logic [7:0]        opc_i,
  input  logic [1:0]        size_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [XLEN-1:0]   dst_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              valid_o,
  output logic              illegal_o,
  output logic [XLEN-1:0]   data_o,
  output logic [FLAG_W-1:0] flags_o
);
  ctl_t            ctl;
  logic [XLEN-1:0] ext;
  logic [XLEN-1:0] res;

  ext_move_decode i_decode (
    .esc_i  (esc_i),
    .opc_i  (opc_i),
    .size_i (size_i),
    .ctl_o  (ctl)
  );

  ext_move_extend #(.XLEN(XLEN)) i_extend (
    .src_i  (src_i),
    .srcw_i (ctl.srcw),
    .sext_i (ctl.sext),
    .ext_o  (ext)
  );

  ext_move_merge #(.XLEN(XLEN)) i_merge (
    .ext_i     (ext),
    .dst_i     (dst_i),
    .dsz_i     (ctl.dsz),
    .illegal_i (ctl.illegal),
    .res_o     (res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      illegal_o <= 1'b0;
      data_o    <= '0;
      flags_o   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        illegal_o <= ctl.illegal;
        data_o    <= res;
        flags_o   <= flags_i;
      end
    end
  end
endmodule

// File: rtl/ext_move_chk.sv
module ext_move_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned FLAG_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic              esc_i,
  input logic [7:0]        opc_i,
  input logic [1:0]        size_i,
  input logic [XLEN-1:0]   src_i,
  input logic [XLEN-1:0]   dst_i,
  input logic [FLAG_W-1:0] flags_i,
  input logic              valid_o,
  input logic              illegal_o,
  input logic [XLEN-1:0]   data_o,
  input logic [FLAG_W-1:0] flags_o
);
  logic legal;
  assign legal = (size_i != 2'd3) &&
                 ((esc_i && (opc_i == 8'hB6 || opc_i == 8'hB7 ||
                             opc_i == 8'hBE || opc_i == 8'hBF)) ||
                  (!esc_i && opc_i == 8'h63));

  // R1
  always_comb begin
    if (!rst_ni) begin
      reset_state_chk: assert (!valid_o && !illegal_o && data_o == '0 && flags_o == '0);
    end
  end

  // R10
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i));

  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o) && $stable(flags_o) && $stable(illegal_o));

  // R9
  flag_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> flags_o == $past(flags_i));

  // R11
  illegal_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !legal) |=> illegal_o && data_o == $past(dst_i));

  // R11
  legal_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal) |=> !illegal_o);

  // R5
  upper_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal && size_i == 2'd1) |=> data_o[XLEN-1:32] == '0);

  // R5 R8
  upper_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && legal && size_i == 2'd0) |=> data_o[XLEN-1:16] == $past(dst_i[XLEN-1:16]));

  // R2
  byte_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && esc_i && opc_i == 8'hBE && size_i == 2'd2) |=>
      data_o[XLEN-1:8] == {(XLEN-8){data_o[7]}});

  // R6
  word_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !esc_i && opc_i == 8'h63 && size_i == 2'd2) |=>
      data_o[XLEN-1:32] == {(XLEN-32){data_o[31]}} && data_o[31:0] == $past(src_i[31:0]));
endmodule

bind ext_move_unit ext_move_chk #(.XLEN(XLEN), .FLAG_W(FLAG_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .esc_i     (esc_i),
  .opc_i     (opc_i),
  .size_i    (size_i),
  .src_i     (src_i),
  .dst_i     (dst_i),
  .flags_i   (flags_i),
  .valid_o   (valid_o),
  .illegal_o (illegal_o),
  .data_o    (data_o),
  .flags_o   (flags_o)
);

// File: tb/test_ext_move_unit.sv
`timescale 1ns/1ps
module test_ext_move_unit;
  localparam int unsigned XLEN   = 64;
  localparam int unsigned FLAG_W = 8;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              valid_i = 1'b0;
  logic              esc_i = 1'b0;
  logic [7:0]        opc_i = '0;
  logic [1:0]        size_i = '0;
  logic [XLEN-1:0]   src_i = '0;
  logic [XLEN-1:0]   dst_i = '0;
  logic [FLAG_W-1:0] flags_i = '0;
  logic              valid_o;
  logic              illegal_o;
  logic [XLEN-1:0]   data_o;
  logic [FLAG_W-1:0] flags_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ext_move_unit #(.XLEN(XLEN), .FLAG_W(FLAG_W)) i_ext_move_unit (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .esc_i(esc_i),
    .opc_i(opc_i), .size_i(size_i), .src_i(src_i), .dst_i(dst_i),
    .flags_i(flags_i), .valid_o(valid_o), .illegal_o(illegal_o),
    .data_o(data_o), .flags_o(flags_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_legal(bit e, logic [7:0] o, logic [1:0] s);
    if (s == 2'd3) return 1'b0;
    if (e) return (o == 8'hB6 || o == 8'hB7 || o == 8'hBE || o == 8'hBF);
    return o == 8'h63;
  endfunction

  function automatic logic [63:0] model(bit e, logic [7:0] o, logic [1:0] s,
                                        logic [63:0] src, logic [63:0] dst);
    int unsigned w;
    bit sg;
    logic [63:0] v;
    if (!is_legal(e, o, s)) return dst;
    if (e) begin
      w  = (o == 8'hB6 || o == 8'hBE) ? 8 : 16;
      sg = (o == 8'hBE || o == 8'hBF);
    end else begin
      w  = (s == 2'd0) ? 16 : 32;
      sg = (s == 2'd2);
    end
    v = src & ((64'd1 << w) - 64'd1);
    if (sg && src[w-1]) v = v - (64'd1 << w);
    case (s)
      2'd0:    return (dst & ~64'hFFFF) | (v & 64'hFFFF);
      2'd1:    return v & 64'hFFFF_FFFF;
      default: return v;
    endcase
  endfunction

  function automatic string tag_of(bit e, logic [7:0] o, logic [1:0] s);
    if (!is_legal(e, o, s)) return "R11";
    if (e) begin
      if (o == 8'hBE) return "R2";
      if (o == 8'hBF) return "R3";
      return "R4";
    end
    if (s == 2'd2) return "R6";
    if (s == 2'd1) return "R7";
    return "R8";
  endfunction

  task automatic run_op(bit e, logic [7:0] o, logic [1:0] s,
                        logic [63:0] src, logic [63:0] dst, logic [7:0] fl);
    logic [63:0] exp;
    bit lg;
    @(negedge clk);
    valid_i = 1'b1; esc_i = e; opc_i = o; size_i = s;
    src_i = src; dst_i = dst; flags_i = fl;
    exp = model(e, o, s, src, dst);
    lg  = is_legal(e, o, s);
    @(posedge clk);
    #1;
    chk("R10 valid", 64'(valid_o), 64'd1);
    chk("R11 illegal flag", 64'(illegal_o), 64'(!lg));
    chk(tag_of(e, o, s), data_o, exp);
    chk("R9 flags", 64'(flags_o), 64'(fl));
    if (lg && e && s == 2'd1) chk("R5 upper clear", data_o >> 32, 64'd0);
    if (lg && e && s == 2'd0) chk("R5 upper keep", data_o >> 16, dst >> 16);
  endtask

  logic [63:0] pat [4];

  initial begin
    pat[0] = 64'hFEDC_BA98_7654_3210;
    pat[1] = 64'h0123_4567_89AB_CDEF;
    pat[2] = 64'h5555_5555_AAAA_7F80;
    pat[3] = 64'hAAAA_AAAA_0000_8000;

    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", 64'(valid_o), 64'd0);
    chk("R1 illegal", 64'(illegal_o), 64'd0);
    chk("R1 data", data_o, 64'd0);
    chk("R1 flags", 64'(flags_o), 64'd0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int e = 0; e < 2; e++)
      for (int s = 0; s < 4; s++)
        for (int o = 0; o < 256; o++)
          for (int p = 0; p < 4; p++)
            run_op(bit'(e), 8'(o), 2'(s), pat[p],
                   ~pat[(p + 1) % 4] ^ 64'(o), 8'(o + p * 17 + s));

    // idle hold after a legal op
    run_op(1'b1, 8'hBE, 2'd2, pat[1], pat[0], 8'h5A);
    @(negedge clk);
    valid_i = 1'b0; esc_i = 1'b0; opc_i = 8'h00; src_i = '1; dst_i = '0; flags_i = 8'hFF;
    @(posedge clk);
    #1;
    chk("R10 idle valid", 64'(valid_o), 64'd0);
    chk("R10 idle data", data_o, 64'hFFFF_FFFF_FFFF_FFEF);
    chk("R10 idle flags", 64'(flags_o), 64'h5A);
    chk("R10 idle illegal", 64'(illegal_o), 64'd0);

    // idle hold after an illegal op
    run_op(1'b0, 8'hB6, 2'd1, pat[2], pat[3], 8'h33);
    @(negedge clk);
    valid_i = 1'b0; esc_i = 1'b1; opc_i = 8'hB6; size_i = 2'd1;
    @(posedge clk);
    #1;
    chk("R10 idle illegal held", 64'(illegal_o), 64'd1);
    chk("R10 idle data held", data_o, pat[3]);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule